// File: doc/BRIEF.md
# System Control Port Decoder

This block answers byte-wide accesses to a small set of legacy board control ports on a single-cycle I/O bus. Each access carries a 16-bit port address and a read or write strobe. Reads return either a fixed identity value for the port or the contents of a stored register. The read data is registered. Any port the block does not decode reads back as all-ones.

On the write side, the block holds an 8-bit system control register and a two-bit lock state. The lock state gates protection of a non-volatile store that sits elsewhere. Each lock bit has its own port, and any write to that port flips the bit. Three mode requests that the platform cannot honour are not stored: soft reset, little-endian operation and a non-contiguous I/O map. Each of these raises a single-cycle event output, so that a supervisor block can act on it.

Top module: `sysctl_port_block`

## Requirements
- R1: While `rst_n` is low at a clock edge, the system control register, both lock bits and all three events clear to 0, and `io_rdata` becomes 0xFF.
- R2: A read of any port address not listed in R3, R5, R7 or R8, including 0x0810, 0x0812, 0x0808 and 0x0814, returns 0xFF.
- R3: A read of port 0x0092 returns 0x40. A write there with data bit 7 set makes `soft_reset_evt` high for exactly the one cycle after the write.
- R4: A write to port 0x0092 with data bit 6 set makes `endian_req_evt` high for exactly the one cycle after the write.
- R5: A read of port 0x080C returns 0xFC.
- R6: Any write to port 0x0810 inverts `lock_state[0]`, and any write to port 0x0812 inverts `lock_state[1]`, whatever the data. No other access changes `lock_state`.
- R7: Port 0x081C is read/write. A read returns the byte most recently written there.
- R8: Port 0x0818 reads 0x00, port 0x0823 reads 0x03 and port 0x0850 reads 0x00.
- R9: A write to port 0x0850 with data bit 7 set makes `iomap_req_evt` high for exactly the one cycle after the write.
- R10: Writes to ports 0x0808 and 0x0814 change neither the system control register, `lock_state` nor any event.
- R11: `io_rdata` is updated at the clock edge that samples `io_rd` high. It holds its value while `io_rd` is low.
- R12: An event is high only in the cycle after a qualifying write. A write with the trigger bit clear, or a read, raises none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Port address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| lock_state | output | 2 | Protection lock bits |
| soft_reset_evt | output | 1 | Soft reset request pulse |
| endian_req_evt | output | 1 | Little-endian request pulse |
| iomap_req_evt | output | 1 | Non-contiguous map request pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data path and two lock bits. With these defaults every decoded port and both lock ports can be reached directly. The bench toggles each lock bit twice to show that the bit returns to its starting value. It also writes trigger patterns with one, both or none of the special-port bits set, so that the pulse width and the independence of the events can both be observed.

// File: rtl/sysctl_pkg.sv
// Package: port addresses, fixed read values and trigger bit positions
// shared by the decoder, the state logic and the read mux.
package sysctl_pkg;
    localparam int PORT_W = 16;
    localparam int BYTE_W = 8;
    localparam int LOCK_N = 2;

    localparam logic [PORT_W-1:0] PORT_SPECIAL = 16'h0092;
    localparam logic [PORT_W-1:0] PORT_LIGHT   = 16'h0808;
    localparam logic [PORT_W-1:0] PORT_EQUIP   = 16'h080C;
    localparam logic [PORT_W-1:0] PORT_L2INV   = 16'h0814;
    localparam logic [PORT_W-1:0] PORT_KEY     = 16'h0818;
    localparam logic [PORT_W-1:0] PORT_CTRL    = 16'h081C;
    localparam logic [PORT_W-1:0] PORT_CACHEID = 16'h0823;
    localparam logic [PORT_W-1:0] PORT_MAP     = 16'h0850;
    // lock bit i is toggled by a write to LOCK_PORT[i]
    localparam logic [PORT_W-1:0] LOCK_PORT [LOCK_N] = '{16'h0810, 16'h0812};

    localparam logic [BYTE_W-1:0] VAL_SPECIAL = 8'h40;
    localparam logic [BYTE_W-1:0] VAL_EQUIP   = 8'hFC;
    localparam logic [BYTE_W-1:0] VAL_KEY     = 8'h00;
    localparam logic [BYTE_W-1:0] VAL_CACHEID = 8'h03;
    localparam logic [BYTE_W-1:0] VAL_MAP     = 8'h00;
    localparam logic [BYTE_W-1:0] VAL_IDLE    = 8'hFF;

    localparam int BIT_SOFTRST = 7;
    localparam int BIT_ENDIAN  = 6;
    localparam int BIT_NONCONT = 7;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SPECIAL, SEL_LIGHT, SEL_EQUIP, SEL_L2INV,
        SEL_KEY, SEL_CTRL, SEL_CACHEID, SEL_MAP, SEL_LOCK
    } port_sel_e;
endpackage

// File: rtl/sysctl_decode.sv
// Module: sysctl_decode
// Turns a port address into a one-of-N port selector plus a per-bit lock
// hit vector. Purely combinational; assumes the address is stable while
// a strobe is high.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = PORT_W,
    parameter int LOCKS  = LOCK_N
) (
    input  logic [ADDR_W-1:0]  addr,
    output port_sel_e          sel,
    output logic [LOCKS-1:0]   lock_hit
);
    // compare against each lock port
    for (genvar g = 0; g < LOCKS; g++) begin : g_lock
        assign lock_hit[g] = (addr == ADDR_W'(LOCK_PORT[g]));
    end

    // map fixed addresses to a selector
    always_comb begin
        sel = SEL_NONE;
        if      (addr == ADDR_W'(PORT_SPECIAL)) sel = SEL_SPECIAL;
        else if (addr == ADDR_W'(PORT_LIGHT))   sel = SEL_LIGHT;
        else if (addr == ADDR_W'(PORT_EQUIP))   sel = SEL_EQUIP;
        else if (addr == ADDR_W'(PORT_L2INV))   sel = SEL_L2INV;
        else if (addr == ADDR_W'(PORT_KEY))     sel = SEL_KEY;
        else if (addr == ADDR_W'(PORT_CTRL))    sel = SEL_CTRL;
        else if (addr == ADDR_W'(PORT_CACHEID)) sel = SEL_CACHEID;
        else if (addr == ADDR_W'(PORT_MAP))     sel = SEL_MAP;
        else if (|lock_hit)                     sel = SEL_LOCK;
    end
endmodule

// File: rtl/sysctl_state.sv
// Module: sysctl_state
// Holds the system control register and the lock bits, and turns
// qualifying writes into one-cycle event pulses. Assumes one write
// strobe cycle per bus write.
module sysctl_state
    import sysctl_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int LOCKS  = LOCK_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  port_sel_e         sel,
    input  logic [LOCKS-1:0]  lock_hit,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [LOCKS-1:0]  lock_q,
    output logic              soft_reset_evt,
    output logic              endian_req_evt,
    output logic              iomap_req_evt
);
    // control register load
    always_ff @(posedge clk) begin
        if (!rst_n)                      ctrl_q <= '0;
        else if (wr && sel == SEL_CTRL)  ctrl_q <= wdata;
    end

    // one toggle flop per lock bit
    for (genvar g = 0; g < LOCKS; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (!rst_n)                 lock_q[g] <= 1'b0;
            else if (wr && lock_hit[g]) lock_q[g] <= ~lock_q[g];
        end
    end

    // event pulses, registered one cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_reset_evt <= 1'b0;
            endian_req_evt <= 1'b0;
            iomap_req_evt  <= 1'b0;
        end else begin
            soft_reset_evt <= wr && sel == SEL_SPECIAL && wdata[BIT_SOFTRST];
            endian_req_evt <= wr && sel == SEL_SPECIAL && wdata[BIT_ENDIAN];
            iomap_req_evt  <= wr && sel == SEL_MAP && wdata[BIT_NONCONT];
        end
    end
endmodule

// File: rtl/sysctl_readmux.sv
// Module: sysctl_readmux
// Selects the read value for the decoded port and registers it on a read
// strobe. Undecoded and write-only ports read as all-ones.
module sysctl_readmux
    import sysctl_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  port_sel_e         sel,
    input  logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rsel;

    // pick the value for the selected port
    always_comb begin
        case (sel)
            SEL_SPECIAL: rsel = DATA_W'(VAL_SPECIAL);
            SEL_EQUIP:   rsel = DATA_W'(VAL_EQUIP);
            SEL_KEY:     rsel = DATA_W'(VAL_KEY);
            SEL_CTRL:    rsel = ctrl_q;
            SEL_CACHEID: rsel = DATA_W'(VAL_CACHEID);
            SEL_MAP:     rsel = DATA_W'(VAL_MAP);
            default:     rsel = {DATA_W{1'b1}};
        endcase
    end

    // capture on read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= DATA_W'(VAL_IDLE);
        else if (rd) rdata <= rsel;
    end
endmodule

// File: rtl/sysctl_port_block.sv
// Module: sysctl_port_block
// Top of the system control port decoder: decode, state and read mux.
// Assumes single-cycle strobes on a byte-wide bus; reset is synchronous
// and active low.
module sysctl_port_block
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = PORT_W,
    parameter int DATA_W = BYTE_W,
    parameter int LOCKS  = LOCK_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic [LOCKS-1:0]  lock_state,
    output logic              soft_reset_evt,
    output logic              endian_req_evt,
    output logic              iomap_req_evt
);
    port_sel_e         sel;
    logic [LOCKS-1:0]  lock_hit;
    logic [DATA_W-1:0] ctrl_q;

    sysctl_decode #(.ADDR_W(ADDR_W), .LOCKS(LOCKS)) u_decode (
        .addr(io_addr), .sel(sel), .lock_hit(lock_hit)
    );

    sysctl_state #(.DATA_W(DATA_W), .LOCKS(LOCKS)) u_state (
        .clk(clk), .rst_n(rst_n), .wr(io_wr), .wdata(io_wdata),
        .sel(sel), .lock_hit(lock_hit), .ctrl_q(ctrl_q), .lock_q(lock_state),
        .soft_reset_evt(soft_reset_evt), .endian_req_evt(endian_req_evt),
        .iomap_req_evt(iomap_req_evt)
    );

    sysctl_readmux #(.DATA_W(DATA_W)) u_rmux (
        .clk(clk), .rst_n(rst_n), .rd(io_rd), .sel(sel),
        .ctrl_q(ctrl_q), .rdata(io_rdata)
    );
endmodule

// File: rtl/sysctl_port_checker.sv
// Module: sysctl_port_checker
// Port-level temporal checks for sysctl_port_block, attached by bind.
module sysctl_port_checker
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = PORT_W,
    parameter int DATA_W = BYTE_W,
    parameter int LOCKS  = LOCK_N
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic [LOCKS-1:0]  lock_state,
    input logic              soft_reset_evt,
    input logic              endian_req_evt,
    input logic              iomap_req_evt
);
    logic special_w, map_w, lock_w, known;
    assign special_w = io_wr && io_addr == ADDR_W'(PORT_SPECIAL);
    assign map_w     = io_wr && io_addr == ADDR_W'(PORT_MAP);
    assign lock_w    = io_wr && (io_addr == ADDR_W'(LOCK_PORT[0]) ||
                                 io_addr == ADDR_W'(LOCK_PORT[1]));
    assign known = io_addr == ADDR_W'(PORT_SPECIAL) || io_addr == ADDR_W'(PORT_EQUIP) ||
                   io_addr == ADDR_W'(PORT_KEY)     || io_addr == ADDR_W'(PORT_CTRL)  ||
                   io_addr == ADDR_W'(PORT_CACHEID) || io_addr == ADDR_W'(PORT_MAP);

    a_r3_soft_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_evt |-> $past(special_w && io_wdata[BIT_SOFTRST]));
    a_r4_endian_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        endian_req_evt |-> $past(special_w && io_wdata[BIT_ENDIAN]));
    a_r9_map_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        iomap_req_evt |-> $past(map_w && io_wdata[BIT_NONCONT]));
    a_r12_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (special_w && io_wdata[BIT_SOFTRST]) |=> soft_reset_evt);
    a_r6_lock_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == ADDR_W'(LOCK_PORT[0])) |=> lock_state[0] != $past(lock_state[0]));
    a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_w |=> $stable(lock_state));
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));
    a_r2_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !known) |=> io_rdata == {DATA_W{1'b1}});
endmodule

bind sysctl_port_block sysctl_port_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCKS(LOCKS)
) u_checker (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .lock_state(lock_state),
    .soft_reset_evt(soft_reset_evt), .endian_req_evt(endian_req_evt),
    .iomap_req_evt(iomap_req_evt)
);

// File: tb/sysctl_port_block_bench.sv
module sysctl_port_block_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [1:0]  lock_state;
    logic        soft_reset_evt, endian_req_evt, iomap_req_evt;
    int          n_checks = 0;
    int          n_errors = 0;

    always #4 clk = ~clk;

    sysctl_port_block u_sysctl_port_block (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .lock_state(lock_state),
        .soft_reset_evt(soft_reset_evt), .endian_req_evt(endian_req_evt),
        .iomap_req_evt(iomap_req_evt)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] evts();
        return {5'b0, iomap_req_evt, endian_req_evt, soft_reset_evt};
    endfunction

    // one write cycle; returns at the negedge after the capturing edge
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic t_reset();
        check("R1 rdata", io_rdata, 8'hFF);
        check("R1 lock", {6'b0, lock_state}, 8'h00);
        check("R1 events", evts(), 8'h00);
    endtask

    task automatic t_fixed_reads();
        logic [7:0] d;
        bus_read(16'h0092, d); check("R3 special read", d, 8'h40);
        bus_read(16'h080C, d); check("R5 equip read", d, 8'hFC);
        bus_read(16'h0818, d); check("R8 key read", d, 8'h00);
        bus_read(16'h0823, d); check("R8 cache id read", d, 8'h03);
        bus_read(16'h0850, d); check("R8 map read", d, 8'h00);
        bus_read(16'h081C, d); check("R1 ctrl reset", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        bus_read(16'h0000, d); check("R2 addr 0000", d, 8'hFF);
        bus_read(16'h0810, d); check("R2 lock port", d, 8'hFF);
        bus_read(16'h0808, d); check("R2 light port", d, 8'hFF);
        bus_read(16'h0814, d); check("R2 l2inv port", d, 8'hFF);
        bus_read(16'h081D, d); check("R2 near ctrl", d, 8'hFF);
    endtask

    task automatic t_ctrl_hold();
        logic [7:0] d;
        bus_write(16'h081C, 8'hC3);
        bus_read(16'h081C, d); check("R7 ctrl C3", d, 8'hC3);
        bus_write(16'h081C, 8'h5A);
        bus_read(16'h081C, d); check("R7 ctrl 5A", d, 8'h5A);
        repeat (3) @(negedge clk);
        check("R11 rdata held", io_rdata, 8'h5A);
    endtask

    task automatic t_locks();
        bus_write(16'h0810, 8'h00); check("R6 lock0 set", {6'b0, lock_state}, 8'h01);
        bus_write(16'h0812, 8'hFF); check("R6 lock1 set", {6'b0, lock_state}, 8'h03);
        bus_write(16'h0810, 8'hFF); check("R6 lock0 back", {6'b0, lock_state}, 8'h02);
        bus_write(16'h0812, 8'h00); check("R6 lock1 back", {6'b0, lock_state}, 8'h00);
    endtask

    task automatic t_events();
        bus_write(16'h0092, 8'h80); check("R3 soft pulse", evts(), 8'h01);
        @(negedge clk);             check("R3 soft one cycle", evts(), 8'h00);
        bus_write(16'h0092, 8'h40); check("R4 endian pulse", evts(), 8'h02);
        @(negedge clk);             check("R4 endian one cycle", evts(), 8'h00);
        bus_write(16'h0092, 8'hC0); check("R12 both special", evts(), 8'h03);
        bus_write(16'h0850, 8'h80); check("R9 map pulse", evts(), 8'h04);
        @(negedge clk);             check("R9 map one cycle", evts(), 8'h00);
        bus_write(16'h0092, 8'h3F); check("R12 no trigger bits", evts(), 8'h00);
        bus_write(16'h0850, 8'h7F); check("R12 map bit clear", evts(), 8'h00);
        bus_write(16'h0500, 8'hFF); check("R12 other port", evts(), 8'h00);
    endtask

    task automatic t_no_effect();
        logic [7:0] d;
        bus_write(16'h081C, 8'h81);
        bus_write(16'h0810, 8'h00);
        bus_write(16'h0808, 8'hFF); check("R10 light evts", evts(), 8'h00);
        bus_write(16'h0814, 8'hFF); check("R10 l2inv evts", evts(), 8'h00);
        check("R10 lock", {6'b0, lock_state}, 8'h01);
        bus_read(16'h081C, d); check("R10 ctrl", d, 8'h81);
    endtask

    task automatic t_reset_again();
        logic [7:0] d;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        bus_read(16'h081C, d); check("R1 ctrl cleared", d, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed_reads();
        t_unmapped();
        t_ctrl_hold();
        t_locks();
        t_events();
        t_no_effect();
        t_reset_again();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule